// File: doc/BRIEF.md
# Lane Metaframe Generator

This block assembles the transmit stream of one lane into fixed-length metaframes. Each metaframe opens with a synchronization word and a scrambler-state word, continues with payload slots, and closes with a diagnostic word. The diagnostic word carries the lane and link health bits and a CRC-32 over the whole metaframe. Payload is pulled from a show-ahead transmit FIFO through a read strobe. When the FIFO cannot supply a word, or the metaframe has been marked as filler, a SKIP control word takes the slot.

Two decisions are made once per metaframe, when its synchronization word is produced. The first is whether the payload slots may draw from the FIFO at all (the burst-enable input). The second is which health status the closing diagnostic word reports. Changes to either input after that point take effect only in the following metaframe. A parameter selects burst gating. When gating is off, every metaframe draws data. A registered start indication marks the first two words of every metaframe.

A four-state machine sequences the words: `ST_SYNC` → `ST_SCRAM` → `ST_PAYLOAD` (held for `MF_LEN-3` slots) → `ST_DIAG` → back to `ST_SYNC`. The state names the word being formed. That word appears on the outputs one clock later.

Top module: `ilk_mf_gen`

## Requirements
- R1: Each metaframe is `MF_LEN` words in the order synchronization, scrambler state, `MF_LEN-3` payload slots, diagnostic. The fixed words are: synchronization = 64'h78F6_78F6_78F6_78F6; scrambler state = {8'h28, SCRAM_SEED}; SKIP = 64'h1E00_0000_0000_0000; diagnostic = {8'h64, 22'h0, status[1:0], crc[31:0]}. `out_ctrl` is 1 for these four kinds of word and 0 for FIFO data.
- R2: `out_sof` is high for exactly two consecutive cycles, together with the synchronization and scrambler-state words, and low for every other word.
- R3: Diagnostic bits [33:32] carry `link_status` as sampled when that metaframe's synchronization word was formed. Bit 1 means the lane is up and bit 0 means the link is up. A change later in the metaframe appears only in the next diagnostic word.
- R4: `burst_en` is sampled once per metaframe, at the same point as `link_status`. A change later in the metaframe does not alter that metaframe's payload or reads.
- R5: When the sampled burst-enable is 0, no `fifo_rd` is issued during that metaframe and every payload slot is SKIP.
- R6: When the sampled burst-enable is 1, each payload slot for which `fifo_empty` is 0 asserts `fifo_rd` for one cycle. The word then carries `fifo_data` with `out_ctrl`=0 on the next cycle, in FIFO order.
- R7: A payload slot for which `fifo_empty` is 1 issues no read and carries SKIP.
- R8: Diagnostic bits [31:0] hold a CRC-32 over all `MF_LEN` words of the metaframe, with the diagnostic CRC field taken as zero. It uses polynomial 0x04C11DB7, starts from all ones, processes each word MSB first, and the final value is inverted.
- R9: With `BURST_MODE`=0, `burst_en` has no effect and every non-empty payload slot reads the FIFO.
- R10: While `rst_n` is low, `out_word`, `out_ctrl`, `out_sof` and `fifo_rd` are 0. The first word after reset release is the synchronization word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| burst_en | input | 1 | 1 = metaframe may draw FIFO data; 0 = SKIP filler |
| link_status | input | 2 | Health bits for the diagnostic word (bit 1 lane, bit 0 link) |
| fifo_empty | input | 1 | Transmit FIFO has no word available |
| fifo_data | input | 64 | Head word of the show-ahead FIFO |
| fifo_rd | output | 1 | Pop the FIFO head word |
| out_word | output | 64 | Output word, one per cycle |
| out_ctrl | output | 1 | 1 = control word, 0 = payload data |
| out_sof | output | 1 | Metaframe start indication |

## Verification
The payload logic is driven with a frame of full data, a frame of pure filler, and a data frame with scattered empty slots. These separate the three slot outcomes: a read with data, SKIP because of gating, and SKIP because of starvation. Before each change of mode, a lead metaframe is captured in which `burst_en` and `link_status` switch halfway through. That frame must still match the old values, so a design that samples continuously is caught, as is one that applies the status to the diagnostic word already under way. A second instance with gating disabled runs beside the first while filler frames are requested. It shows that the variant ignores the gate. The CRC is recomputed for every frame, so the data content feeds into the check.

// File: rtl/ilmf_pkg.sv
package ilmf_pkg;

    localparam int WORD_W = 64;

    localparam logic [WORD_W-1:0] SYNC_WORD = 64'h78F6_78F6_78F6_78F6;
    localparam logic [7:0]        TAG_SCRAM = 8'h28;
    localparam logic [7:0]        TAG_SKIP  = 8'h1E;
    localparam logic [7:0]        TAG_DIAG  = 8'h64;
    localparam logic [31:0]       CRC_POLY  = 32'h04C1_1DB7;

    typedef enum logic [1:0] {
        ST_SYNC,
        ST_SCRAM,
        ST_PAYLOAD,
        ST_DIAG
    } mf_state_e;

    // One 64-bit word folded into a running CRC-32, most significant bit first.
    function automatic logic [31:0] crc32_fold(input logic [31:0] seed,
                                               input logic [WORD_W-1:0] data);
        logic [31:0] c;
        logic        fb;
        c = seed;
        for (int b = WORD_W - 1; b >= 0; b--) begin
            fb = c[31] ^ data[b];
            c  = {c[30:0], 1'b0};
            if (fb) begin
                c = c ^ CRC_POLY;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/ilmf_fsm.sv
module ilmf_fsm
    import ilmf_pkg::*;
#(
    parameter int MF_LEN = 2048
) (
    input  logic      clk,
    input  logic      rst_n,
    output mf_state_e state,
    output logic      start_now,
    output logic      pay_now,
    output logic      diag_now,
    output logic      sof_next
);

    localparam int PAY_SLOTS = MF_LEN - 3;
    localparam int CNT_W     = $clog2(PAY_SLOTS + 1);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(PAY_SLOTS - 1);

    mf_state_e        state_q, state_d;
    logic [CNT_W-1:0] slot_q, slot_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SYNC;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        unique case (state_q)
            ST_SYNC: begin
                state_d = ST_SCRAM;
            end
            ST_SCRAM: begin
                state_d = ST_PAYLOAD;
                slot_d  = '0;
            end
            ST_PAYLOAD: begin
                if (slot_q == LAST_SLOT) begin
                    state_d = ST_DIAG;
                end else begin
                    slot_d = slot_q + 1'b1;
                end
            end
            ST_DIAG: begin
                state_d = ST_SYNC;
            end
        endcase
    end

    // Decoded outputs
    always_comb begin
        state     = state_q;
        start_now = (state_q == ST_SYNC);
        pay_now   = (state_q == ST_PAYLOAD);
        diag_now  = (state_q == ST_DIAG);
        sof_next  = (state_q == ST_SYNC) || (state_q == ST_SCRAM);
    end

endmodule

// File: rtl/ilmf_slot.sv
module ilmf_slot #(
    parameter bit BURST_MODE = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_now,
    input  logic       pay_now,
    input  logic       burst_en,
    input  logic [1:0] link_status,
    input  logic       fifo_empty,
    output logic       burst_q,
    output logic [1:0] status_q,
    output logic       take_data
);

    // Health bits frozen for the whole metaframe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 2'b00;
        end else if (start_now) begin
            status_q <= link_status;
        end
    end

    generate
        if (BURST_MODE) begin : g_gated
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    burst_q <= 1'b0;
                end else if (start_now) begin
                    burst_q <= burst_en;
                end
            end
        end else begin : g_always
            assign burst_q = 1'b1;
        end
    endgenerate

    assign take_data = pay_now && burst_q && !fifo_empty;

endmodule

// File: rtl/ilmf_crc.sv
module ilmf_crc
    import ilmf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              first,
    input  logic [WORD_W-1:0] word_in,
    output logic [31:0]       crc_out
);

    logic [31:0] acc_q;
    logic [31:0] base;
    logic [31:0] folded;

    always_comb begin
        base    = first ? 32'hFFFF_FFFF : acc_q;
        folded  = crc32_fold(base, word_in);
        crc_out = ~folded;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= 32'hFFFF_FFFF;
        end else begin
            acc_q <= folded;
        end
    end

endmodule

// File: rtl/ilk_mf_gen.sv
module ilk_mf_gen
    import ilmf_pkg::*;
#(
    parameter int          MF_LEN     = 2048,
    parameter bit          BURST_MODE = 1'b1,
    parameter logic [55:0] SCRAM_SEED = 56'h00_5A5A_0000_0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        burst_en,
    input  logic [1:0]  link_status,
    input  logic        fifo_empty,
    input  logic [63:0] fifo_data,
    output logic        fifo_rd,
    output logic [63:0] out_word,
    output logic        out_ctrl,
    output logic        out_sof
);

    mf_state_e   state;
    logic        start_now;
    logic        pay_now;
    logic        diag_now;
    logic        sof_next;
    logic        burst_q;
    logic [1:0]  status_q;
    logic        take_data;
    logic [63:0] word_d;
    logic        ctrl_d;
    logic [31:0] crc_val;

    ilmf_fsm #(
        .MF_LEN(MF_LEN)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .start_now(start_now),
        .pay_now  (pay_now),
        .diag_now (diag_now),
        .sof_next (sof_next)
    );

    ilmf_slot #(
        .BURST_MODE(BURST_MODE)
    ) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_now  (start_now),
        .pay_now    (pay_now),
        .burst_en   (burst_en),
        .link_status(link_status),
        .fifo_empty (fifo_empty),
        .burst_q    (burst_q),
        .status_q   (status_q),
        .take_data  (take_data)
    );

    // Word formed this cycle, with the diagnostic CRC field still zero
    always_comb begin
        word_d = '0;
        ctrl_d = 1'b1;
        unique case (state)
            ST_SYNC:    word_d = SYNC_WORD;
            ST_SCRAM:   word_d = {TAG_SCRAM, SCRAM_SEED};
            ST_PAYLOAD: begin
                if (take_data) begin
                    word_d = fifo_data;
                    ctrl_d = 1'b0;
                end else begin
                    word_d = {TAG_SKIP, 56'h0};
                end
            end
            ST_DIAG:    word_d = {TAG_DIAG, 22'h0, status_q, 32'h0};
        endcase
    end

    ilmf_crc u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .first  (start_now),
        .word_in(word_d),
        .crc_out(crc_val)
    );

    assign fifo_rd = take_data;

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_word <= '0;
            out_ctrl <= 1'b0;
            out_sof  <= 1'b0;
        end else begin
            out_word <= diag_now ? {word_d[63:32], crc_val} : word_d;
            out_ctrl <= ctrl_d;
            out_sof  <= sof_next;
        end
    end

endmodule

// File: rtl/ilk_mf_gen_sva.sv
module ilk_mf_gen_sva
    import ilmf_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        fifo_empty,
    input logic        fifo_rd,
    input logic [63:0] out_word,
    input logic        out_ctrl,
    input logic        out_sof,
    input logic        burst_q,
    input logic        start_now
);

    AST_SOF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_sof) |=> out_sof); // R2

    AST_SOF_END: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof && $past(out_sof)) |=> !out_sof); // R2

    AST_NO_READ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty); // R7

    AST_READ_GIVES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |=> !out_ctrl); // R6

    AST_SYNC_AFTER_DIAG: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ctrl && out_word[63:56] == TAG_DIAG) |=> (out_word == SYNC_WORD && out_sof)); // R1

    AST_BURST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !start_now |=> $stable(burst_q)); // R4

endmodule

bind ilk_mf_gen ilk_mf_gen_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_empty(fifo_empty),
    .fifo_rd   (fifo_rd),
    .out_word  (out_word),
    .out_ctrl  (out_ctrl),
    .out_sof   (out_sof),
    .burst_q   (burst_q),
    .start_now (start_now)
);

// File: tb/ilk_mf_gen_bench.sv
`timescale 1ns/1ps
module ilk_mf_gen_bench;

    localparam int          MFL     = 16;
    localparam logic [63:0] W_SYNC  = 64'h78F6_78F6_78F6_78F6;
    localparam logic [63:0] W_SCRAM = 64'h2800_5A5A_0000_0001;
    localparam logic [63:0] W_SKIP  = 64'h1E00_0000_0000_0000;
    localparam logic [63:0] NB_DATA = 64'hA5A5_0000_0000_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        burst_en;
    logic [1:0]  status;
    logic        fifo_empty;
    logic [63:0] fifo_data;
    logic        fifo_rd, out_ctrl, out_sof;
    logic [63:0] out_word;
    logic        fifo_rd_nb, out_ctrl_nb, out_sof_nb;
    logic [63:0] out_word_nb;

    int vec = 0;
    int bad = 0;
    int rd_count = 0;
    int rd_nb = 0;

    logic [63:0] cap_w [MFL];
    logic        cap_c [MFL];
    logic        cap_s [MFL];
    logic [63:0] cap_wn[MFL];
    logic        cap_cn[MFL];
    logic [63:0] cap_base;
    int          nb_reads;
    logic        cur_burst;
    logic [1:0]  cur_status;

    always #2 clk = ~clk;

    ilk_mf_gen #(.MF_LEN(MFL), .BURST_MODE(1'b1)) u_ilk_mf_gen (
        .clk(clk), .rst_n(rst_n), .burst_en(burst_en), .link_status(status),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
        .out_word(out_word), .out_ctrl(out_ctrl), .out_sof(out_sof)
    );

    ilk_mf_gen #(.MF_LEN(MFL), .BURST_MODE(1'b0)) u_ilk_mf_gen_nb (
        .clk(clk), .rst_n(rst_n), .burst_en(burst_en), .link_status(status),
        .fifo_empty(1'b0), .fifo_data(NB_DATA), .fifo_rd(fifo_rd_nb),
        .out_word(out_word_nb), .out_ctrl(out_ctrl_nb), .out_sof(out_sof_nb)
    );

    // Show-ahead FIFO model: head advances on each pop
    always @(posedge clk) begin
        if (fifo_rd && !fifo_empty) begin
            fifo_data <= fifo_data + 64'd1;
            rd_count  <= rd_count + 1;
        end
        if (fifo_rd_nb) begin
            rd_nb <= rd_nb + 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input bit use_nb);
        logic [31:0] c;
        logic [63:0] d;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < MFL; k++) begin
            d = use_nb ? cap_wn[k] : cap_w[k];
            if (k == MFL - 1) d[31:0] = 32'h0;
            for (int b = 63; b >= 0; b--) begin
                fb = c[31] ^ d[b];
                c  = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C1_1DB7;
            end
        end
        return ~c;
    endfunction

    // Capture one metaframe; optionally switch inputs at word index chg_at
    task automatic grab_frame(input logic [MFL-1:0] starve, input int chg_at,
                              input logic nb, input logic [1:0] ns, output int reads);
        int r0, n0;
        @(negedge clk);
        while (!(out_sof && out_word == W_SYNC)) @(negedge clk);
        r0 = rd_count;
        n0 = rd_nb;
        cap_base = fifo_data;
        for (int i = 0; i < MFL; i++) begin
            if (i > 0) @(negedge clk);
            cap_w[i]  = out_word;
            cap_c[i]  = out_ctrl;
            cap_s[i]  = out_sof;
            cap_wn[i] = out_word_nb;
            cap_cn[i] = out_ctrl_nb;
            fifo_empty = (i + 1 < MFL) ? starve[i+1] : 1'b0;
            if (i == chg_at) begin
                burst_en = nb;
                status   = ns;
            end
        end
        reads    = rd_count - r0;
        nb_reads = rd_nb - n0;
        fifo_empty = 1'b0;
    endtask

    task automatic check_frame(input logic eb, input logic [1:0] es,
                               input logic [MFL-1:0] starve, input int reads,
                               input bit lead);
        logic [63:0] nxt;
        int          exp_reads;
        string       lbl;
        nxt = cap_base;
        exp_reads = 0;
        lbl = lead ? "R4" : (eb ? "R6" : "R5");
        chk("R1", "sync word", cap_w[0], W_SYNC);
        chk("R1", "sync ctrl", 64'(cap_c[0]), 64'd1);
        chk("R1", "scrambler word", cap_w[1], W_SCRAM);
        chk("R2", "sof word0", 64'(cap_s[0]), 64'd1);
        chk("R2", "sof word1", 64'(cap_s[1]), 64'd1);
        chk("R2", "sof word2", 64'(cap_s[2]), 64'd0);
        chk("R2", "sof diag", 64'(cap_s[MFL-1]), 64'd0);
        for (int i = 2; i < MFL - 1; i++) begin
            if (eb && starve[i]) begin
                chk("R7", "starved slot", cap_w[i], W_SKIP);
                chk("R7", "starved ctrl", 64'(cap_c[i]), 64'd1);
            end else if (eb) begin
                chk(lbl, "data slot", cap_w[i], nxt);
                chk(lbl, "data ctrl", 64'(cap_c[i]), 64'd0);
                nxt = nxt + 64'd1;
                exp_reads++;
            end else begin
                chk(lbl, "skip slot", cap_w[i], W_SKIP);
                chk(lbl, "skip ctrl", 64'(cap_c[i]), 64'd1);
            end
            chk("R9", "gate-off slot", cap_wn[i], NB_DATA);
            chk("R9", "gate-off ctrl", 64'(cap_cn[i]), 64'd0);
        end
        chk(lbl, "fifo reads", 64'(reads), 64'(exp_reads));
        chk("R9", "gate-off reads", 64'(nb_reads), 64'(MFL - 3));
        chk("R1", "diag tag", 64'(cap_w[MFL-1][63:56]), 64'h64);
        chk("R1", "diag ctrl", 64'(cap_c[MFL-1]), 64'd1);
        chk("R3", "diag status", 64'(cap_w[MFL-1][33:32]), 64'(es));
        chk("R8", "diag crc", 64'(cap_w[MFL-1][31:0]), 64'(ref_crc(1'b0)));
        chk("R8", "gate-off crc", 64'(cap_wn[MFL-1][31:0]), 64'(ref_crc(1'b1)));
    endtask

    // Lead frame switches inputs midway and must keep the old values
    task automatic run_pair(input logic nb, input logic [1:0] ns, input logic [MFL-1:0] starve);
        int reads;
        grab_frame('0, 8, nb, ns, reads);
        check_frame(cur_burst, cur_status, '0, reads, 1'b1);
        cur_burst  = nb;
        cur_status = ns;
        grab_frame(starve, -1, nb, ns, reads);
        check_frame(cur_burst, cur_status, starve, reads, 1'b0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R10", "reset word", out_word, 64'h0);
        chk("R10", "reset ctrl", 64'(out_ctrl), 64'd0);
        chk("R10", "reset sof", 64'(out_sof), 64'd0);
        chk("R10", "reset rd", 64'(fifo_rd), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "first word", out_word, W_SYNC);
        chk("R10", "first sof", 64'(out_sof), 64'd1);
    endtask

    task automatic t_data_basic();
        run_pair(1'b1, 2'b11, '0);
    endtask

    task automatic t_skip_frame();
        run_pair(1'b0, 2'b10, '0);
    endtask

    task automatic t_resume_data();
        run_pair(1'b1, 2'b01, '0);
    endtask

    task automatic t_starved();
        logic [MFL-1:0] m;
        m = '0;
        m[3] = 1'b1;
        m[4] = 1'b1;
        m[9] = 1'b1;
        m[MFL-2] = 1'b1;
        run_pair(1'b1, 2'b00, m);
    endtask

    initial begin
        #(4 * 20000);
        bad++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        burst_en   = 1'b1;
        status     = 2'b11;
        fifo_empty = 1'b0;
        fifo_data  = 64'h0000_0000_0000_1000;
        cur_burst  = 1'b1;
        cur_status = 2'b11;
        t_reset();
        t_data_basic();
        t_skip_frame();
        t_resume_data();
        t_starved();
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule